// File: doc/BRIEF.md
# Redundant Bus Clock Fallback Controller

This block watches the two redundant timing references of a time-slot switching device, called the A set and the B set, and decides what to do when one of them fails. Watchdog circuits outside the block give one failure pulse per monitored clock. The block synchronizes these pulses, drops the ones for clocks that software has masked, and latches the rest into sticky error flags. When fallback is armed and a monitored clock in the active selection fails, a small state machine picks the recovery action. That action depends on the role that software has programmed: slave, A-set master or B-set master.

A slave only moves its synchronization reference to the other set. It never starts to drive bus clocks by itself. A master that sees its own clocks fail takes all of its clock drivers off the bus. A master that sees the other set's master fail becomes the primary source and drives the compatibility clocks as well. While any fallback state is active, a divided-down copy of the local crystal clock is given out as the substitute timing source. Software gets one interrupt pulse when the block enters fallback and a level status bit. It reprograms the role and selection, then writes the clear strobe. The clear empties the flags and returns the block to normal operation.

Top module: `bus_clk_fallback`

## Requirements
- R1: After reset the role is slave, fallback is disarmed, every watchdog is masked, the clock selection is empty and the primary reference is A. All three output enables are 0, `ref_sel` is 0, `err_flags` is 0, both interrupt outputs are 0 and `fb_clk` is 0.
- R2: A watchdog pulse sampled at clock edge k passes a two-stage synchronizer. It can set its error flag at edge k+2 at the earliest, and it is not visible after edge k+1.
- R3: A failure on a masked clock (mask bit 0) sets no flag and causes no state change. Writing an all-zero mask therefore stops any new errors.
- R4: Fallback starts from normal operation only when all three of these hold: the arm bit is 1, at least one selected clock has a qualified failure, and every clock in the selection is unmasked. A qualified failure that misses any of these conditions still sets its flag, but it changes no output other than `err_flags`.
- R5: In the slave role, and in the spare role encoding 11 (which behaves as a slave), fallback moves `ref_sel` to the opposite of the programmed primary reference (0 = A set, 1 = B set). All three output enables stay 0 in every state.
- R6: In normal operation, an A master (role 01) drives `oe_a` and a B master (role 10) drives `oe_b`. `oe_compat` is driven only by the master whose own set equals the programmed primary reference. `ref_sel` follows the primary reference.
- R7: When a master enters fallback with a failure of any selected clock other than the other set's clock (bit 0 = A, bit 1 = B), it enters a removed state with all output enables at 0. This case wins when both kinds of failure arrive together.
- R8: When a master enters fallback only because the other set's clock failed, it enters a takeover state. It drives its own set enable and `oe_compat`, and `ref_sel` points at its own set.
- R9: While the block is in any fallback state, `fb_clk` is the clock divided by 4: it is high in cycles 2 and 3 of a 4-cycle count that starts at reset. In normal operation it is 0.
- R10: Error flags stay set until `err_clr` is sampled high. The clear empties the flags and `irq_status` and returns the block to normal operation. A failure qualified in the same cycle as the clear is discarded.
- R11: Entering a fallback state gives `irq_pulse` high for exactly one cycle, the first cycle of the new state. `irq_status` rises at the same time and stays high until a clear.
- R12: Configuration writes (`cfg_wr` = 1) choose a register with `cfg_addr`. Address 0 holds the control word: bits [1:0] role (00 slave, 01 A master, 10 B master, 11 spare), bit 2 the fallback arm and bit 3 the primary reference. Address 1 holds the watchdog mask (1 = unmasked). Address 2 holds the clock selection. The role changes only through such a write, so a slave in fallback is never promoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | DW | Configuration write data |
| wd_fail | input | WD_N | Per-clock watchdog failure pulses (asynchronous) |
| err_clr | input | 1 | Software clear of flags and fallback state |
| ref_sel | output | 1 | Synchronization reference in use, 0 = A, 1 = B |
| oe_a | output | 1 | Output enable for the A bus clocks |
| oe_b | output | 1 | Output enable for the B bus clocks |
| oe_compat | output | 1 | Output enable for the compatibility clocks |
| fb_clk | output | 1 | Divided crystal clock, active only in fallback |
| err_flags | output | WD_N | Sticky per-clock error flags |
| irq_pulse | output | 1 | One-cycle interrupt on fallback entry |
| irq_status | output | 1 | Level interrupt status, held until cleared |

## Verification
The hardest situation to reach is a clear that meets a failure that has just been qualified. The synchronizer hides the failure for two edges, so the bench has to time `err_clr` against the delayed copy of the pulse, not against the pulse it drives. The bench does this by placing the clear exactly two edges after the pulse is sampled. A close second is a master that receives its own failure and the other set's failure in the same cycle. The bench drives both watchdog bits in one pulse to check that removal wins. A reference model runs cycle by cycle through every role change, mask change and clear, so each of these corners is compared on every clock as well as by the directed checks.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    // Role encoding of the control word, bits [1:0]
    typedef enum logic [1:0] {
        ROLE_SLAVE  = 2'b00,
        ROLE_MAST_A = 2'b01,
        ROLE_MAST_B = 2'b10,
        ROLE_SPARE  = 2'b11
    } role_e;

    typedef enum logic [1:0] {
        FB_NORMAL   = 2'd0,
        FB_SWAPPED  = 2'd1,
        FB_REMOVED  = 2'd2,
        FB_TAKEOVER = 2'd3
    } fb_state_e;

    // Configuration register addresses
    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_SEL  = 2'd2;

    // Watchdog bit positions of the two redundant clock sets
    localparam int SET_A = 0;
    localparam int SET_B = 1;

    localparam int CTL_W = 4;

    // Control word: bit3 primary reference, bit2 arm, bits1:0 role
    typedef struct packed {
        logic  pri_b;
        logic  fb_en;
        role_e role;
    } ctl_t;

    // Classified fallback event
    typedef struct packed {
        logic trig;
        logic own_fail;
        logic other_fail;
    } evt_t;

    // Bus drive decision
    typedef struct packed {
        logic oe_a;
        logic oe_b;
        logic oe_compat;
        logic ref_b;
    } drive_t;

    function automatic logic is_master(role_e r);
        return (r == ROLE_MAST_A) || (r == ROLE_MAST_B);
    endfunction

    function automatic logic own_is_b(role_e r);
        return r == ROLE_MAST_B;
    endfunction

    function automatic int other_idx(role_e r);
        return (r == ROLE_MAST_B) ? SET_A : SET_B;
    endfunction

endpackage

// File: rtl/bcf_sync.sv
module bcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    // One two-stage synchronizer per watchdog lane
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic st1_q;
        logic st2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1_q <= 1'b0;
                st2_q <= 1'b0;
            end else begin
                st1_q <= d_async[g];
                st2_q <= st1_q;
            end
        end
        assign d_sync[g] = st2_q;
    end
endmodule

// File: rtl/bcf_cfg.sv
module bcf_cfg
    import bcf_pkg::*;
#(
    parameter int WD_N = 4,
    parameter int DW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output ctl_t            ctl,
    output logic [WD_N-1:0] mask,
    output logic [WD_N-1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '{pri_b: 1'b0, fb_en: 1'b0, role: ROLE_SLAVE};
            mask <= '0;
            sel  <= '0;
        end else if (wr) begin
            unique case (addr)
                ADDR_CTL:  ctl  <= ctl_t'(wdata[CTL_W-1:0]);
                ADDR_MASK: mask <= wdata[WD_N-1:0];
                ADDR_SEL:  sel  <= wdata[WD_N-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/bcf_detect.sv
module bcf_detect
    import bcf_pkg::*;
#(
    parameter int WD_N = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [WD_N-1:0] fail_s,
    input  logic [WD_N-1:0] mask,
    input  logic [WD_N-1:0] sel,
    input  ctl_t            ctl,
    input  logic            clr,
    output logic [WD_N-1:0] flags,
    output evt_t            evt
);
    logic [WD_N-1:0] qual;
    logic [WD_N-1:0] qual_sel;
    logic [WD_N-1:0] other_bit;
    logic            sel_covered;

    always_comb begin
        qual        = fail_s & mask;
        qual_sel    = qual & sel;
        sel_covered = ((sel & ~mask) == '0);
        other_bit   = '0;
        other_bit[other_idx(ctl.role)] = 1'b1;

        evt.trig       = ctl.fb_en && (qual_sel != '0) && sel_covered;
        evt.other_fail = |(qual_sel & other_bit);
        evt.own_fail   = |(qual_sel & ~other_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) flags <= '0;
        else            flags <= flags | qual;
    end
endmodule

// File: rtl/bcf_fsm.sv
module bcf_fsm
    import bcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_t      evt,
    input  role_e     role,
    input  logic      clr,
    output fb_state_e state,
    output logic      irq_pulse,
    output logic      irq_status
);
    fb_state_e state_d;
    logic      enter;

    always_comb begin
        state_d = state;
        enter   = 1'b0;
        if (clr) begin
            state_d = FB_NORMAL;
        end else if (state == FB_NORMAL && evt.trig) begin
            enter = 1'b1;
            if (!is_master(role))  state_d = FB_SWAPPED;
            else if (evt.own_fail) state_d = FB_REMOVED;
            else                   state_d = FB_TAKEOVER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FB_NORMAL;
            irq_pulse  <= 1'b0;
            irq_status <= 1'b0;
        end else begin
            state     <= state_d;
            irq_pulse <= enter;
            if (clr)        irq_status <= 1'b0;
            else if (enter) irq_status <= 1'b1;
        end
    end
endmodule

// File: rtl/bus_clk_fallback.sv
module bus_clk_fallback
    import bcf_pkg::*;
#(
    parameter int WD_N   = 4,
    parameter int FB_DIV = 4,
    parameter int DW     = (WD_N > CTL_W) ? WD_N : CTL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [WD_N-1:0] wd_fail,
    input  logic            err_clr,
    output logic            ref_sel,
    output logic            oe_a,
    output logic            oe_b,
    output logic            oe_compat,
    output logic            fb_clk,
    output logic [WD_N-1:0] err_flags,
    output logic            irq_pulse,
    output logic            irq_status
);
    localparam int CW = (FB_DIV > 2) ? $clog2(FB_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FB_DIV - 1);
    localparam logic [CW-1:0] CNT_HIGH = CW'(FB_DIV / 2);

    ctl_t            ctl;
    logic [WD_N-1:0] mask;
    logic [WD_N-1:0] sel;
    logic [WD_N-1:0] fail_s;
    evt_t            evt;
    fb_state_e       state;
    drive_t          drv;
    logic [CW-1:0]   div_q;
    logic            in_fb;
    logic [1:0]      role_bits;
    logic [1:0]      st_bits;

    bcf_cfg #(.WD_N(WD_N), .DW(DW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ctl   (ctl),
        .mask  (mask),
        .sel   (sel)
    );

    bcf_sync #(.W(WD_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (wd_fail),
        .d_sync  (fail_s)
    );

    bcf_detect #(.WD_N(WD_N)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .fail_s (fail_s),
        .mask   (mask),
        .sel    (sel),
        .ctl    (ctl),
        .clr    (err_clr),
        .flags  (err_flags),
        .evt    (evt)
    );

    bcf_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .role       (ctl.role),
        .clr        (err_clr),
        .state      (state),
        .irq_pulse  (irq_pulse),
        .irq_status (irq_status)
    );

    // Crystal divider, free running from reset
    always_ff @(posedge clk) begin
        if (rst)                  div_q <= '0;
        else if (div_q == CNT_LAST) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    assign in_fb  = (state != FB_NORMAL);
    assign fb_clk = in_fb && (div_q >= CNT_HIGH);

    // Bus drive decision
    always_comb begin
        drv       = '0;
        drv.ref_b = ctl.pri_b;
        if (state == FB_SWAPPED)
            drv.ref_b = ~ctl.pri_b;
        else if (state == FB_TAKEOVER && is_master(ctl.role))
            drv.ref_b = own_is_b(ctl.role);

        if (is_master(ctl.role) && state != FB_REMOVED) begin
            drv.oe_a      = !own_is_b(ctl.role);
            drv.oe_b      = own_is_b(ctl.role);
            drv.oe_compat = (state == FB_TAKEOVER) || (own_is_b(ctl.role) == ctl.pri_b);
        end
    end

    assign ref_sel   = drv.ref_b;
    assign oe_a      = drv.oe_a;
    assign oe_b      = drv.oe_b;
    assign oe_compat = drv.oe_compat;

    assign role_bits = ctl.role;
    assign st_bits   = state;
endmodule

// File: rtl/bcf_checker.sv
module bcf_checker
    import bcf_pkg::*;
#(
    parameter int WD_N = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            err_clr,
    input logic            oe_a,
    input logic            oe_b,
    input logic            oe_compat,
    input logic            fb_clk,
    input logic            irq_pulse,
    input logic            irq_status,
    input logic [WD_N-1:0] err_flags,
    input logic [1:0]      role_bits,
    input logic [1:0]      st_bits
);
    logic slave_like;
    assign slave_like = (role_bits == ROLE_SLAVE) || (role_bits == ROLE_SPARE);

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        slave_like |-> (!oe_a && !oe_b && !oe_compat)); // R5

    AST_REMOVED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_bits == FB_REMOVED) |-> (!oe_a && !oe_b && !oe_compat)); // R7

    AST_TAKEOVER_COMPAT: assert property (@(posedge clk) disable iff (rst)
        (st_bits == FB_TAKEOVER && !slave_like) |-> oe_compat); // R8

    AST_FBCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_bits == FB_NORMAL) |-> !fb_clk); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R10

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (err_flags == '0 && !irq_status)); // R10

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R11

    AST_PULSE_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_status); // R11
endmodule

bind bus_clk_fallback bcf_checker #(.WD_N(WD_N)) u_bcf_chk (
    .clk        (clk),
    .rst        (rst),
    .err_clr    (err_clr),
    .oe_a       (oe_a),
    .oe_b       (oe_b),
    .oe_compat  (oe_compat),
    .fb_clk     (fb_clk),
    .irq_pulse  (irq_pulse),
    .irq_status (irq_status),
    .err_flags  (err_flags),
    .role_bits  (role_bits),
    .st_bits    (st_bits)
);

// File: tb/bus_clk_fallback_bench.sv
`timescale 1ns/1ps
module bus_clk_fallback_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [3:0] cfg_wdata = 4'd0;
    logic [3:0] wd_fail = 4'd0;
    logic       err_clr = 1'b0;
    logic       ref_sel, oe_a, oe_b, oe_compat, fb_clk, irq_pulse, irq_status;
    logic [3:0] err_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int       m_role, m_st, m_tick;
    bit       m_fben, m_pri, m_pulse, m_stat;
    bit [3:0] m_mask, m_sel, m_p1, m_p2, m_flags;

    always #2 clk = ~clk; // 250 MHz

    bus_clk_fallback u_bus_clk_fallback (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wd_fail(wd_fail), .err_clr(err_clr),
        .ref_sel(ref_sel), .oe_a(oe_a), .oe_b(oe_b), .oe_compat(oe_compat),
        .fb_clk(fb_clk), .err_flags(err_flags), .irq_pulse(irq_pulse),
        .irq_status(irq_status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_role = 0; m_fben = 0; m_pri = 0; m_mask = 0; m_sel = 0;
            m_p1 = 0; m_p2 = 0; m_st = 0; m_flags = 0; m_pulse = 0;
            m_stat = 0; m_tick = 0;
        end else begin
            bit [3:0] hit, chosen;
            bit fire, mast;
            int nxt, rival;
            hit    = m_p2 & m_mask;
            chosen = hit & m_sel;
            mast   = (m_role == 1) || (m_role == 2);
            fire   = !err_clr && m_st == 0 && m_fben && chosen != 0 && (m_sel & ~m_mask) == 0;
            nxt    = m_st;
            if (err_clr) nxt = 0;
            else if (fire) begin
                if (!mast) nxt = 1;
                else begin
                    rival = (m_role == 2) ? 0 : 1;
                    nxt = ((chosen & ~(4'b1 << rival)) != 0) ? 2 : 3;
                end
            end
            m_pulse = fire;
            if (err_clr) m_stat = 0; else if (fire) m_stat = 1;
            m_flags = err_clr ? 4'd0 : (m_flags | hit);
            m_st    = nxt;
            m_p2    = m_p1;
            m_p1    = wd_fail;
            m_tick  = (m_tick + 1) % 4;
            if (cfg_wr) begin
                if (cfg_addr == 0) begin
                    m_role = cfg_wdata[1:0]; m_fben = cfg_wdata[2]; m_pri = cfg_wdata[3];
                end else if (cfg_addr == 1) m_mask = cfg_wdata;
                else if (cfg_addr == 2) m_sel = cfg_wdata;
            end
        end
    end

    // Compare on every clock, shortly after the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            bit mast, own, e_ref, e_a, e_b, e_c, e_fb;
            mast  = (m_role == 1) || (m_role == 2);
            own   = (m_role == 2);
            e_ref = (m_st == 1) ? !m_pri : ((m_st == 3 && mast) ? own : m_pri);
            e_a   = (m_role == 1) && m_st != 2;
            e_b   = (m_role == 2) && m_st != 2;
            e_c   = mast && m_st != 2 && (m_st == 3 || own == m_pri);
            e_fb  = (m_st != 0) && (m_tick >= 2);
            chk(ref_sel == e_ref, "R5 ref_sel", ref_sel, e_ref);
            chk({oe_a, oe_b, oe_compat} == {e_a, e_b, e_c}, "R6/R7/R8 enables",
                {oe_a, oe_b, oe_compat}, {e_a, e_b, e_c});
            chk(fb_clk == e_fb, "R9 fb_clk", fb_clk, e_fb);
            chk(err_flags == m_flags, "R2 err_flags", err_flags, m_flags);
            chk(irq_pulse == m_pulse, "R11 irq_pulse", irq_pulse, m_pulse);
            chk(irq_status == m_stat, "R11 irq_status", irq_status, m_stat);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit [1:0] a, input bit [3:0] d);
        @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic pulse_wd(input bit [3:0] b);
        @(negedge clk); wd_fail = b;
        @(negedge clk); wd_fail = 0;
    endtask

    task automatic clear();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        int highs;
        cyc(4);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk({oe_a, oe_b, oe_compat, ref_sel} == 0, "R1 outputs", {oe_a, oe_b, oe_compat, ref_sel}, 0);
        chk(err_flags == 0 && !irq_pulse && !irq_status && !fb_clk, "R1 flags/irq",
            {err_flags, irq_pulse, irq_status, fb_clk}, 0);

        // R3 masked by reset default
        pulse_wd(4'b0011); cyc(4);
        chk(err_flags == 0 && !irq_status, "R3 masked failure", err_flags, 0);

        // R12 configuration, R2 latency, R4 disarmed
        cfg(2'd1, 4'b1111);
        cfg(2'd2, 4'b0011);
        pulse_wd(4'b0010);
        cyc(1);
        chk(err_flags == 0, "R2 not visible after k+1", err_flags, 0);
        cyc(1);
        chk(err_flags == 4'b0010, "R2 visible after k+2", err_flags, 4'b0010);
        chk(!irq_status && ref_sel == 0, "R4 disarmed no fallback", irq_status, 0);
        cyc(10);
        chk(err_flags == 4'b0010, "R10 sticky flag", err_flags, 4'b0010);
        clear();
        chk(err_flags == 0, "R10 clear", err_flags, 0);

        // R4 selection not fully unmasked
        cfg(2'd0, 4'b0100);       // slave, armed, primary A
        cfg(2'd1, 4'b0001);
        pulse_wd(4'b0001); cyc(3);
        chk(err_flags == 4'b0001 && !irq_status, "R4 partially masked selection",
            {err_flags, irq_status}, 5'b00010);
        clear();

        // R5 slave swap, R11 pulse, R9 divider
        cfg(2'd1, 4'b1111);
        pulse_wd(4'b0001); cyc(2);
        chk(irq_pulse == 1, "R11 pulse on entry", irq_pulse, 1);
        cyc(1);
        chk(irq_pulse == 0 && irq_status == 1, "R11 single pulse, level held",
            {irq_pulse, irq_status}, 2'b01);
        chk(ref_sel == 1 && {oe_a, oe_b, oe_compat} == 0, "R5 slave swap",
            {ref_sel, oe_a, oe_b, oe_compat}, 4'b1000);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1; highs += fb_clk;
        end
        chk(highs == 4, "R9 divide by 4 in fallback", highs, 4);
        clear();
        chk(ref_sel == 0 && !fb_clk, "R10 clear returns to normal", {ref_sel, fb_clk}, 0);

        // R6 A master normal, R8 takeover
        cfg(2'd0, 4'b0101);
        cyc(1);
        chk({oe_a, oe_b, oe_compat} == 3'b101, "R6 A master primary", {oe_a, oe_b, oe_compat}, 3'b101);
        pulse_wd(4'b0010); cyc(3);
        chk({oe_a, oe_b, oe_compat, ref_sel} == 4'b1010, "R8 A takeover",
            {oe_a, oe_b, oe_compat, ref_sel}, 4'b1010);
        clear();

        // R6 B master backup, R8 takeover from B
        cfg(2'd0, 4'b0110);
        cyc(1);
        chk({oe_a, oe_b, oe_compat} == 3'b010, "R6 B master backup", {oe_a, oe_b, oe_compat}, 3'b010);
        pulse_wd(4'b0001); cyc(3);
        chk({oe_a, oe_b, oe_compat, ref_sel} == 4'b0111, "R8 B takeover",
            {oe_a, oe_b, oe_compat, ref_sel}, 4'b0111);
        clear();

        // R7 own and other together: removal wins
        cfg(2'd0, 4'b0101);
        pulse_wd(4'b0011); cyc(3);
        chk({oe_a, oe_b, oe_compat} == 0 && irq_status, "R7 self removal priority",
            {oe_a, oe_b, oe_compat, irq_status}, 4'b0001);
        clear();

        // R7 own failure of a non-set clock in selection
        cfg(2'd2, 4'b0110);
        cfg(2'd0, 4'b1110);       // B master, primary B
        pulse_wd(4'b0100); cyc(3);
        chk({oe_a, oe_b, oe_compat} == 0, "R7 B master own loss", {oe_a, oe_b, oe_compat}, 0);
        clear();

        // R10 clear meets a just-qualified failure
        cfg(2'd2, 4'b0011);
        cfg(2'd0, 4'b0100);
        pulse_wd(4'b0001);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        chk(err_flags == 0 && !irq_status, "R10 clear discards same-cycle failure",
            {err_flags, irq_status}, 0);
        cyc(3);
        chk(ref_sel == 0, "R10 stays normal", ref_sel, 0);

        // R12 role change only by write; spare role acts as slave
        cfg(2'd0, 4'b0111);
        pulse_wd(4'b0010); cyc(3);
        chk({oe_a, oe_b, oe_compat} == 0 && ref_sel == 1, "R12 spare role no promotion",
            {oe_a, oe_b, oe_compat, ref_sel}, 4'b0001);
        clear();

        // R3 zero mask stops new errors
        cfg(2'd1, 4'b0000);
        pulse_wd(4'b1111); cyc(4);
        chk(err_flags == 0 && !irq_status, "R3 zero mask", err_flags, 0);

        cyc(2);
        finish_run();
    end
endmodule